// File: doc/BRIEF.md
# Random Number Generator Register Interface

This block places a pseudo-random byte source behind a three-byte register window. A control byte holds a writable enable bit and a read-only bit showing that a generator is fitted. A status byte shows whether a fresh random byte is waiting. A data byte returns that random byte.

Software first reads the control byte to find the generator. It then sets the enable bit and reads it back to confirm the enable took effect. After that it polls the status byte and reads the data byte whenever a byte is waiting. Reading the data byte clears the waiting flag, so each byte is handed out once.

The entropy source is modelled by a Galois LFSR. The LFSR steps once per enabled cycle. A pacing counter hands the low byte of the LFSR state to the data register once every `SAMPLE_PERIOD` enabled cycles. The register port is synchronous. A read strobe loads `rd_data` on the next clock edge, and `rd_data` keeps that value until the next read.

Top module: `rng_regs`

## Requirements
- R1: Address 0 selects the control byte, address 1 the data-status byte and address 2 the data byte. A read of address 3 returns 0x00.
- R2: Bit 6 of the control byte always reads as the `PRESENT` parameter (1 by default) and cannot be written. Control bits 5..1 and bit 7 read 0.
- R3: A write to address 0 loads bit 0 of the write data into the enable bit. A read issued in the very next cycle returns the new value in bit 0.
- R4: `rd_data` is loaded on the clock edge that samples `rd_en` high. It holds its value in every cycle without a read.
- R5: Bit 0 of the data-status byte reads 1 while a captured byte is waiting. Bits 7..1 read 0.
- R6: A read of address 2 clears the waiting flag, unless a new byte is captured in the same cycle.
- R7: While the generator is enabled, the LFSR (width `LFSR_W`, seed `LFSR_SEED`, taps `LFSR_TAPS`, right-shifting Galois form) steps every cycle. On every `SAMPLE_PERIOD`-th enabled cycle, counted from the cycle after enabling, its low byte before the step is captured as the data byte and the waiting flag is set.
- R8: While the generator is disabled, no byte is captured. The waiting flag is 0 from the cycle after disabling, and the LFSR and the data byte hold their values.
- R9: Writes to addresses 1, 2 and 3 have no effect. Only bit 0 of a write to address 0 has an effect.
- R10: After reset the generator is disabled, the waiting flag is 0, and the data byte and `rd_data` are 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| addr | input | ADDR_W | Register address |
| wr_en | input | 1 | Write strobe |
| wr_data | input | DATA_W | Write data |
| rd_en | input | 1 | Read strobe |
| rd_data | output | DATA_W | Read data, registered |

## Verification
Every internal state is visible through a register read within one cycle of the read strobe. A wrong enable, pacing count or LFSR step therefore shows up on `rd_data` at the next poll. A pacing error appears as a waiting flag that comes early or late against the bench's own count. A wrong LFSR step appears as a byte that differs from the bench's predicted sequence, and the error persists in every later byte. A wrong clear or hold of the waiting flag shows up on the status read that follows a data read, or that follows a disable.

// File: rtl/rng_pkg.sv
`timescale 1ns/1ps
package rng_pkg;
  typedef enum logic [1:0] {
    SEL_CTRL  = 2'd0,
    SEL_STAT  = 2'd1,
    SEL_DATA  = 2'd2,
    SEL_NONE  = 2'd3
  } reg_sel_e;

  localparam int PRESENT_POS = 6;
  localparam int ENABLE_POS  = 0;
  localparam int READY_POS   = 0;
endpackage

// File: rtl/rng_lfsr.sv
`timescale 1ns/1ps
module rng_lfsr #(
  parameter int          W     = 16,
  parameter logic [W-1:0] SEED = 16'hACE1,
  parameter logic [W-1:0] TAPS = 16'hB400
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         adv,
  output logic [W-1:0] state
);
  function automatic logic [W-1:0] next_state(input logic [W-1:0] s);
    logic [W-1:0] n;
    n = s >> 1;
    if (s[0]) n = n ^ TAPS;
    return n;
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   state <= SEED;
    else if (adv) state <= next_state(state);
  end

  // R8: the state holds while stepping is off
  a_r8_lfsr_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !adv |=> $stable(state));
  // R7: a step never reaches the all-zero lock-up state
  a_r7_lfsr_nonzero: assert property (@(posedge clk) disable iff (!rst_n)
    adv |=> state != '0);
endmodule

// File: rtl/rng_pacer.sv
`timescale 1ns/1ps
module rng_pacer #(
  parameter int PERIOD = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic en,
  output logic tick
);
  localparam int CW = (PERIOD > 2) ? $clog2(PERIOD) : 1;
  localparam logic [CW-1:0] LAST = CW'(PERIOD - 1);

  logic [CW-1:0] cnt;

  assign tick = en && (cnt == LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt <= '0;
    else if (!en)    cnt <= '0;
    else if (tick)   cnt <= '0;
    else             cnt <= cnt + 1'b1;
  end

  // R8: the count restarts after a disable
  a_r8_pacer_restart: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> cnt == '0);
  // R7: the count never runs past the period
  a_r7_pacer_bound: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= LAST);
endmodule

// File: rtl/rng_hold.sv
`timescale 1ns/1ps
module rng_hold #(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          en,
  input  logic          fresh,
  input  logic [DW-1:0] fresh_byte,
  input  logic          taken,
  output logic          ready,
  output logic [DW-1:0] value
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      ready <= 1'b0;
    else if (!en)    ready <= 1'b0;
    else if (fresh)  ready <= 1'b1;
    else if (taken)  ready <= 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      value <= '0;
    else if (fresh)  value <= fresh_byte;
  end

  // R8: disabled generator shows no waiting byte
  a_r8_idle_clear: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> !ready);
  // R6: a data read with no new byte consumes the flag
  a_r6_read_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (taken && !fresh) |=> !ready);
  // R7: a delivered byte is stored and flagged
  a_r7_capture: assert property (@(posedge clk) disable iff (!rst_n)
    fresh |=> ready && (value == $past(fresh_byte)));
  // R8: the byte holds when nothing is delivered
  a_r8_value_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !fresh |=> $stable(value));
endmodule

// File: rtl/rng_regs.sv
`timescale 1ns/1ps
module rng_regs
  import rng_pkg::*;
#(
  parameter int          ADDR_W        = 2,
  parameter int          DATA_W        = 8,
  parameter int          LFSR_W        = 16,
  parameter logic [15:0] LFSR_SEED     = 16'hACE1,
  parameter logic [15:0] LFSR_TAPS     = 16'hB400,
  parameter int          SAMPLE_PERIOD = 8,
  parameter bit          PRESENT       = 1'b1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              rd_en,
  output logic [DATA_W-1:0] rd_data
);
  localparam logic [LFSR_W-1:0] SEED_W = LFSR_W'(LFSR_SEED);
  localparam logic [LFSR_W-1:0] TAPS_W = LFSR_W'(LFSR_TAPS);

  reg_sel_e sel;
  logic     ctrl_wr, data_rd;
  logic     en_q;
  logic     fresh;
  logic     ready;
  logic [LFSR_W-1:0] lfsr_state;
  logic [DATA_W-1:0] held;
  logic [DATA_W-1:0] rd_next;
  logic [DATA_W-1:0] unused_wr_bits;

  function automatic reg_sel_e decode(input logic [ADDR_W-1:0] a);
    if (a > ADDR_W'(2)) return SEL_NONE;
    return reg_sel_e'(a[1:0]);
  endfunction

  function automatic logic [DATA_W-1:0] ctrl_byte(input logic en);
    logic [DATA_W-1:0] b;
    b = '0;
    b[PRESENT_POS] = PRESENT;
    b[ENABLE_POS]  = en;
    return b;
  endfunction

  function automatic logic [DATA_W-1:0] stat_byte(input logic rdy);
    logic [DATA_W-1:0] b;
    b = '0;
    b[READY_POS] = rdy;
    return b;
  endfunction

  assign sel            = decode(addr);
  assign ctrl_wr        = wr_en && (sel == SEL_CTRL);
  assign data_rd        = rd_en && (sel == SEL_DATA);
  assign unused_wr_bits = wr_data;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       en_q <= 1'b0;
    else if (ctrl_wr) en_q <= wr_data[ENABLE_POS];
  end

  rng_lfsr #(.W(LFSR_W), .SEED(SEED_W), .TAPS(TAPS_W)) u_lfsr (
    .clk(clk), .rst_n(rst_n), .adv(en_q), .state(lfsr_state)
  );

  rng_pacer #(.PERIOD(SAMPLE_PERIOD)) u_pacer (
    .clk(clk), .rst_n(rst_n), .en(en_q), .tick(fresh)
  );

  rng_hold #(.DW(DATA_W)) u_hold (
    .clk(clk), .rst_n(rst_n), .en(en_q), .fresh(fresh),
    .fresh_byte(lfsr_state[DATA_W-1:0]), .taken(data_rd),
    .ready(ready), .value(held)
  );

  always_comb begin
    unique case (sel)
      SEL_CTRL: rd_next = ctrl_byte(en_q);
      SEL_STAT: rd_next = stat_byte(ready);
      SEL_DATA: rd_next = held;
      default:  rd_next = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     rd_data <= '0;
    else if (rd_en) rd_data <= rd_next;
  end

  // R3: the enable bit follows the written bit 0
  a_r3_enable_write: assert property (@(posedge clk) disable iff (!rst_n)
    ctrl_wr |=> en_q == $past(wr_data[ENABLE_POS]));
  // R9: enable changes only through a control write
  a_r9_enable_only_ctrl: assert property (@(posedge clk) disable iff (!rst_n)
    !ctrl_wr |=> $stable(en_q));
  // R2: the presence bit reads back on control reads
  a_r2_present: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && sel == SEL_CTRL) |=> rd_data[PRESENT_POS] == PRESENT);
  // R4: read data holds without a read strobe
  a_r4_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_en |=> $stable(rd_data));
  // R1: the unmapped address reads zero
  a_r1_unmapped: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && sel == SEL_NONE) |=> rd_data == '0);
endmodule

// File: tb/rng_regs_test.sv
`timescale 1ns/1ps
module rng_regs_test;
  localparam int          AW  = 2;
  localparam int          DW  = 8;
  localparam int          LW  = 16;
  localparam logic [15:0] SEED = 16'hACE1;
  localparam logic [15:0] TAPS = 16'hB400;
  localparam int          PER = 8;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [AW-1:0] addr = '0;
  logic          wr_en = 1'b0;
  logic [DW-1:0] wr_data = '0;
  logic          rd_en = 1'b0;
  logic [DW-1:0] rd_data;

  int checks = 0;
  int errors = 0;

  // reference state, computed from the requirements
  logic          m_en;
  logic          m_rdy;
  logic [DW-1:0] m_data;
  logic [LW-1:0] m_lfsr;
  int            m_cnt;
  logic [DW-1:0] m_rd;

  always #2.5 clk = ~clk;

  rng_regs uut (
    .clk(clk), .rst_n(rst_n), .addr(addr), .wr_en(wr_en),
    .wr_data(wr_data), .rd_en(rd_en), .rd_data(rd_data)
  );

  function automatic logic [LW-1:0] ref_step(input logic [LW-1:0] s);
    logic fb;
    logic [LW-1:0] r;
    fb = s[0];
    r  = {1'b0, s[LW-1:1]};
    for (int i = 0; i < LW; i++) if (TAPS[i] && fb) r[i] = ~r[i];
    return r;
  endfunction

  function automatic logic [DW-1:0] ref_read(input logic [AW-1:0] a);
    case (a)
      2'd0:    return {1'b0, 1'b1, 5'b0, m_en};
      2'd1:    return {7'b0, m_rdy};
      2'd2:    return m_data;
      default: return 8'h00;
    endcase
  endfunction

  task automatic chk(input string tag, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: got %02h expected %02h", tag, act, exp);
    end
  endtask

  task automatic ref_reset();
    m_en = 1'b0; m_rdy = 1'b0; m_data = '0; m_lfsr = SEED; m_cnt = 0; m_rd = '0;
  endtask

  // one bus cycle; the reference advances with the clock edge
  task automatic cyc(input logic w, input logic r, input logic [AW-1:0] a,
                     input logic [DW-1:0] d, input string tag);
    logic fresh;
    wr_en = w; rd_en = r; addr = a; wr_data = d;
    @(posedge clk);
    fresh = m_en && (m_cnt == PER - 1);
    if (r) m_rd = ref_read(a);
    if (!m_en)                       m_rdy = 1'b0;
    else if (fresh)                  m_rdy = 1'b1;
    else if (r && a == 2'd2)         m_rdy = 1'b0;
    if (fresh) m_data = m_lfsr[DW-1:0];
    if (m_en) begin
      m_lfsr = ref_step(m_lfsr);
      m_cnt  = fresh ? 0 : m_cnt + 1;
    end else begin
      m_cnt = 0;
    end
    if (w && a == 2'd0) m_en = d[0];
    @(negedge clk);
    if (r) chk(tag, rd_data, m_rd);
    wr_en = 1'b0; rd_en = 1'b0;
  endtask

  task automatic rd(input logic [AW-1:0] a, input string tag);
    cyc(1'b0, 1'b1, a, 8'h00, tag);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) cyc(1'b0, 1'b0, 2'd0, 8'h00, "idle");
  endtask

  initial begin
    #1_000_000;
    errors++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [DW-1:0] kept;
    void'($urandom(32'd1234));
    ref_reset();
    repeat (3) @(negedge clk);
    chk("R10 rd_data after reset", rd_data, 8'h00);
    rst_n = 1'b1;
    @(negedge clk);

    // reset state through the port
    rd(2'd0, "R10 control after reset");
    chk("R2 presence only", rd_data, 8'h40);
    rd(2'd1, "R10 status after reset");
    rd(2'd2, "R10 data after reset");
    rd(2'd3, "R1 unmapped read");
    chk("R1 unmapped zero", rd_data, 8'h00);

    // enable with all bits set; only bit 0 takes
    cyc(1'b1, 1'b0, 2'd0, 8'hFF, "R9");
    rd(2'd0, "R3 enable readback");
    chk("R3 enable readback value", rd_data, 8'h41);
    kept = rd_data;
    idle(2);
    chk("R4 rd_data holds", rd_data, kept);

    // wait for a byte, read it, then the flag must drop
    idle(PER);
    rd(2'd1, "R5 byte waiting");
    chk("R5 waiting flag value", rd_data, 8'h01);
    rd(2'd2, "R7 first byte");
    rd(2'd1, "R6 flag consumed");

    // writes to non-control registers do nothing
    idle(PER);
    rd(2'd2, "R7 second byte");
    kept = rd_data;
    cyc(1'b1, 1'b0, 2'd2, ~kept, "R9");
    cyc(1'b1, 1'b0, 2'd1, 8'hFF, "R9");
    cyc(1'b1, 1'b0, 2'd3, 8'hFF, "R9");
    rd(2'd2, "R9 data write ignored");
    rd(2'd0, "R9 control intact");

    // disable: no capture, flag stays 0, byte holds
    cyc(1'b1, 1'b0, 2'd0, 8'hFE, "R3");
    rd(2'd2, "R8 data before idle");
    kept = rd_data;
    idle(3 * PER);
    rd(2'd1, "R8 flag stays clear");
    chk("R8 flag zero", rd_data, 8'h00);
    rd(2'd2, "R8 data held");
    chk("R8 data value held", rd_data, kept);
    rd(2'd0, "R3 disable readback");
    chk("R3 disable value", rd_data, 8'h40);

    // random traffic, mostly enabled
    cyc(1'b1, 1'b0, 2'd0, 8'h01, "R3");
    for (int n = 0; n < 4000; n++) begin
      logic w, r;
      logic [AW-1:0] a;
      logic [DW-1:0] d;
      w = ($urandom % 8) == 0;
      r = ($urandom % 2) == 0;
      a = AW'($urandom % 4);
      d = DW'($urandom);
      if (w && a == 2'd0) d[0] = ($urandom % 6) != 0;
      case (a)
        2'd0:    cyc(w, r, a, d, "R3 random control");
        2'd1:    cyc(w, r, a, d, "R5 random status");
        2'd2:    cyc(w, r, a, d, "R7 random data");
        default: cyc(w, r, a, d, "R1 random unmapped");
      endcase
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule